// File: doc/BRIEF.md
# Queue-occupancy QoS port throttler

This block sits beside a memory controller's shared read and write command queues. It stops requestors that do not carry video traffic from filling them, so that queue space is always left for video requests. Every cycle it compares the current read-queue and write-queue occupancies against thresholds held for each port. From those comparisons it drives registered mask bits, one per port for reads and one per port for writes. A set mask bit blocks that port from requesting the port arbiter in that direction. A separate registered output throttles all best-effort traffic once either queue reaches a global threshold.

Each port has four settings that software can program: a read threshold, a write threshold, a hysteresis amount and a class bit that marks the port as video. A set mask bit stays set until the occupancy falls below the threshold minus the hysteresis. This keeps a port from toggling while the queue level hovers around its threshold. The settings are written and read over a plain address / write-enable / data bus. A write commits at a clock edge, and the comparison at the next edge uses the new value.

Top module: `qos_port_throttle`

## Requirements
- R1: While reset is low and right after it is released, all bits of `rd_mask` and `wr_mask` are 0 and `be_throttle` is 0. Every threshold (read, write and best-effort) reads back as QDEPTH, every hysteresis reads 0 and every class bit reads 0.
- R2: The settings for port p sit at addresses 4p+0 (read threshold), 4p+1 (write threshold), 4p+2 (hysteresis) and 4p+3 (class, bit 0 = video, upper bits read 0). The best-effort threshold sits at address 4·NUM_PORTS. `cfg_rdata` shows the addressed setting in the same cycle. Unmapped addresses read 0, and writes to them change no setting.
- R3: For a non-video port p, `rd_mask[p]` is 1 after any clock edge at which `rd_occ` was greater than or equal to that port's read threshold.
- R4: `wr_mask[p]` follows the same rule using `wr_occ` and the port's write threshold. Read occupancy has no effect on write masks, and write occupancy has no effect on read masks.
- R5: A set mask bit of a non-video port stays set while occupancy + hysteresis ≥ threshold. It clears after the first edge at which occupancy + hysteresis < threshold. Hysteresis never sets a bit by itself. If the hysteresis is at least the threshold, a set bit does not clear until reset.
- R6: Mask bits of a port whose class bit is 1 are 0 after every clock edge, whatever the occupancy. This includes a port switched to video while its mask is set.
- R7: `be_throttle` is 1 after any edge at which `rd_occ` or `wr_occ` was greater than or equal to the best-effort threshold, and 0 after any other edge. No hysteresis applies to it.
- R8: A setting written at one clock edge is used by the comparison at the following edge. Masks sampled after the write edge still reflect the old value.
- R9: Occupancy inputs range from 0 to QDEPTH inclusive, and a threshold equal to QDEPTH masks only when the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_occ | input | OCC_W ($clog2(QDEPTH+1)) | Current read command queue occupancy |
| wr_occ | input | OCC_W | Current write command queue occupancy |
| cfg_addr | input | ADDR_W ($clog2(4·NUM_PORTS+1)) | Setting address |
| cfg_wr | input | 1 | Write strobe, commits at the clock edge |
| cfg_wdata | input | OCC_W | Write data |
| cfg_rdata | output | OCC_W | Read data for `cfg_addr`, combinational |
| rd_mask | output | NUM_PORTS | Per-port read request mask, registered |
| wr_mask | output | NUM_PORTS | Per-port write request mask, registered |
| be_throttle | output | 1 | Global best-effort throttle, registered |

## Verification
The assertions take for granted that the occupancy inputs never exceed QDEPTH and that they, like the bus signals, are settled before each rising edge. The mask and throttle properties compare the registered outputs with the inputs and settings seen at the previous edge, so any glitch or out-of-range level would break them. The bench changes occupancy and bus signals only on the falling edge. It drives occupancies only within 0..QDEPTH, including both ends, and it samples the registered outputs one falling edge after the rising edge that loads them.

// File: rtl/qos_thr_pkg.sv
package qos_thr_pkg;

   // Field selector held in the two low address bits of each port's group.
   typedef enum logic [1:0] {
      FLD_RD_THR = 2'd0,
      FLD_WR_THR = 2'd1,
      FLD_HYST   = 2'd2,
      FLD_CLASS  = 2'd3
   } fld_e;

   localparam int unsigned FIELDS_PER_PORT = 4;

endpackage

// File: rtl/qos_thr_regs.sv
module qos_thr_regs
   import qos_thr_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   parameter int DATA_W    = 6,
   parameter int ADDR_W    = 5,
   parameter int HYST_EN   = 1,
   parameter int RST_THR   = 32
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [ADDR_W-1:0]                 cfg_addr,
   input  logic                              cfg_wr,
   input  logic [DATA_W-1:0]                 cfg_wdata,
   output logic [DATA_W-1:0]                 cfg_rdata,
   output logic [NUM_PORTS-1:0][DATA_W-1:0]  rd_thr_o,
   output logic [NUM_PORTS-1:0][DATA_W-1:0]  wr_thr_o,
   output logic [NUM_PORTS-1:0][DATA_W-1:0]  hyst_o,
   output logic [NUM_PORTS-1:0]              video_o,
   output logic [DATA_W-1:0]                 be_thr_o
);

   localparam int          PIDX_W  = ADDR_W - 2;
   localparam int          BE_ADDR = NUM_PORTS * int'(FIELDS_PER_PORT);
   localparam [DATA_W-1:0] THR_RST = DATA_W'(RST_THR);

   logic [PIDX_W-1:0]    port_idx;
   fld_e                 fld;
   logic                 be_hit;
   logic [NUM_PORTS-1:0] port_hit;
   logic                 addr_hit;

   assign port_idx = cfg_addr[ADDR_W-1:2];
   assign fld      = fld_e'(cfg_addr[1:0]);
   assign be_hit   = (cfg_addr == ADDR_W'(BE_ADDR));
   assign addr_hit = (|port_hit) | be_hit;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign port_hit[p] = (port_idx == PIDX_W'(p));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_thr_o[p] <= THR_RST;
            wr_thr_o[p] <= THR_RST;
            video_o[p]  <= 1'b0;
         end else if (cfg_wr && port_hit[p]) begin
            case (fld)
               FLD_RD_THR: rd_thr_o[p] <= cfg_wdata;
               FLD_WR_THR: wr_thr_o[p] <= cfg_wdata;
               FLD_CLASS:  video_o[p]  <= cfg_wdata[0];
               default:    ;
            endcase
         end
      end

      if (HYST_EN != 0) begin : g_hyst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               hyst_o[p] <= '0;
            else if (cfg_wr && port_hit[p] && fld == FLD_HYST)
               hyst_o[p] <= cfg_wdata;
         end
      end else begin : g_no_hyst
         assign hyst_o[p] = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         be_thr_o <= THR_RST;
      else if (cfg_wr && be_hit)
         be_thr_o <= cfg_wdata;
   end

   always_comb begin
      cfg_rdata = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (port_hit[p]) begin
            case (fld)
               FLD_RD_THR: cfg_rdata = rd_thr_o[p];
               FLD_WR_THR: cfg_rdata = wr_thr_o[p];
               FLD_HYST:   cfg_rdata = hyst_o[p];
               FLD_CLASS:  cfg_rdata = DATA_W'(video_o[p]);
               default:    cfg_rdata = '0;
            endcase
         end
      end
      if (be_hit)
         cfg_rdata = be_thr_o;
   end

   // R2
   unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !addr_hit) |=> $stable({rd_thr_o, wr_thr_o, hyst_o, video_o, be_thr_o}))
      else $error("write to unmapped address changed a setting");

endmodule

// File: rtl/qos_mask_cell.sv
module qos_mask_cell #(
   parameter int DATA_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] occ,
   input  logic [DATA_W-1:0] thr,
   input  logic [DATA_W-1:0] hyst,
   input  logic              video,
   output logic              mask_o
);

   // One extra bit so occupancy plus hysteresis cannot wrap.
   logic [DATA_W:0] occ_plus_hyst;
   logic            reach;
   logic            stay;

   assign occ_plus_hyst = {1'b0, occ} + {1'b0, hyst};
   assign reach         = (occ >= thr);
   assign stay          = (occ_plus_hyst >= {1'b0, thr});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_o <= 1'b0;
      else
         mask_o <= !video && (reach || (mask_o && stay));
   end

   // R3
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!video && occ >= thr) |=> mask_o)
      else $error("mask did not set at threshold");

   // R5
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!video && mask_o && ({1'b0, occ} + {1'b0, hyst} >= {1'b0, thr})) |=> mask_o)
      else $error("mask dropped inside hysteresis band");

   // R5
   mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (({1'b0, occ} + {1'b0, hyst}) < {1'b0, thr}) |=> !mask_o)
      else $error("mask stayed set below the band");

   // R6
   video_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      video |=> !mask_o)
      else $error("video port was masked");

endmodule

// File: rtl/qos_be_throttle.sv
module qos_be_throttle #(
   parameter int DATA_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] rd_occ,
   input  logic [DATA_W-1:0] wr_occ,
   input  logic [DATA_W-1:0] thr,
   output logic              throttle_o
);

   logic [DATA_W-1:0] peak;

   assign peak = (rd_occ > wr_occ) ? rd_occ : wr_occ;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         throttle_o <= 1'b0;
      else
         throttle_o <= (peak >= thr);
   end

   // R7
   be_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_occ >= thr || wr_occ >= thr) |=> throttle_o)
      else $error("best-effort throttle missing");

   // R7
   be_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_occ < thr && wr_occ < thr) |=> !throttle_o)
      else $error("best-effort throttle spurious");

endmodule

// File: rtl/qos_port_throttle.sv
module qos_port_throttle
   import qos_thr_pkg::*;
#(
   parameter  int NUM_PORTS = 4,
   parameter  int QDEPTH    = 32,
   parameter  int HYST_EN   = 1,
   localparam int OCC_W     = $clog2(QDEPTH + 1),
   localparam int ADDR_W    = $clog2(NUM_PORTS * int'(FIELDS_PER_PORT) + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [OCC_W-1:0]     rd_occ,
   input  logic [OCC_W-1:0]     wr_occ,
   input  logic [ADDR_W-1:0]    cfg_addr,
   input  logic                 cfg_wr,
   input  logic [OCC_W-1:0]     cfg_wdata,
   output logic [OCC_W-1:0]     cfg_rdata,
   output logic [NUM_PORTS-1:0] rd_mask,
   output logic [NUM_PORTS-1:0] wr_mask,
   output logic                 be_throttle
);

   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("NUM_PORTS must be at least 1");
   end
   if (QDEPTH < 1) begin : g_bad_depth
      $error("QDEPTH must be at least 1");
   end
   if (HYST_EN != 0 && HYST_EN != 1) begin : g_bad_hyst
      $error("HYST_EN must be 0 or 1");
   end

   logic [NUM_PORTS-1:0][OCC_W-1:0] rd_thr;
   logic [NUM_PORTS-1:0][OCC_W-1:0] wr_thr;
   logic [NUM_PORTS-1:0][OCC_W-1:0] hyst;
   logic [NUM_PORTS-1:0]            video;
   logic [OCC_W-1:0]                be_thr;

   qos_thr_regs #(
      .NUM_PORTS (NUM_PORTS),
      .DATA_W    (OCC_W),
      .ADDR_W    (ADDR_W),
      .HYST_EN   (HYST_EN),
      .RST_THR   (QDEPTH)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_addr  (cfg_addr),
      .cfg_wr    (cfg_wr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .rd_thr_o  (rd_thr),
      .wr_thr_o  (wr_thr),
      .hyst_o    (hyst),
      .video_o   (video),
      .be_thr_o  (be_thr)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      qos_mask_cell #(.DATA_W(OCC_W)) u_rd (
         .clk    (clk),
         .rst_n  (rst_n),
         .occ    (rd_occ),
         .thr    (rd_thr[p]),
         .hyst   (hyst[p]),
         .video  (video[p]),
         .mask_o (rd_mask[p])
      );
      qos_mask_cell #(.DATA_W(OCC_W)) u_wr (
         .clk    (clk),
         .rst_n  (rst_n),
         .occ    (wr_occ),
         .thr    (wr_thr[p]),
         .hyst   (hyst[p]),
         .video  (video[p]),
         .mask_o (wr_mask[p])
      );
   end

   qos_be_throttle #(.DATA_W(OCC_W)) u_be (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_occ     (rd_occ),
      .wr_occ     (wr_occ),
      .thr        (be_thr),
      .throttle_o (be_throttle)
   );

   // R9
   occ_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(rd_occ) <= QDEPTH) && (32'(wr_occ) <= QDEPTH))
      else $error("occupancy above queue depth");

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (rd_mask == '0 && wr_mask == '0 && !be_throttle))
      else $error("outputs not idle after reset");

endmodule

// File: tb/qos_port_throttle_bench.sv
module qos_port_throttle_bench;

   localparam int NP     = 4;
   localparam int QD     = 32;
   localparam int OCC_W  = $clog2(QD + 1);
   localparam int ADDR_W = $clog2(NP * 4 + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [OCC_W-1:0]  rd_occ = '0;
   logic [OCC_W-1:0]  wr_occ = '0;
   logic [ADDR_W-1:0] cfg_addr = '0;
   logic              cfg_wr = 1'b0;
   logic [OCC_W-1:0]  cfg_wdata = '0;
   logic [OCC_W-1:0]  cfg_rdata;
   logic [NP-1:0]     rd_mask;
   logic [NP-1:0]     wr_mask;
   logic              be_throttle;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   qos_port_throttle #(.NUM_PORTS(NP), .QDEPTH(QD), .HYST_EN(1)) u_qos_port_throttle (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_occ      (rd_occ),
      .wr_occ      (wr_occ),
      .cfg_addr    (cfg_addr),
      .cfg_wr      (cfg_wr),
      .cfg_wdata   (cfg_wdata),
      .cfg_rdata   (cfg_rdata),
      .rd_mask     (rd_mask),
      .wr_mask     (wr_mask),
      .be_throttle (be_throttle)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_reg(input int addr, input int data);
      cfg_addr  = ADDR_W'(addr);
      cfg_wdata = OCC_W'(data);
      cfg_wr    = 1'b1;
      step();
      cfg_wr    = 1'b0;
   endtask

   task automatic rd_reg(input int addr, output logic [OCC_W-1:0] data);
      cfg_addr = ADDR_W'(addr);
      #1;
      data = cfg_rdata;
   endtask

   task automatic set_occ(input int r, input int w);
      rd_occ = OCC_W'(r);
      wr_occ = OCC_W'(w);
      step();
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n  = 1'b0;
      rd_occ = '0;
      wr_occ = '0;
      cfg_wr = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [OCC_W-1:0] d;
      do_reset();
      wr_reg(0, 1);
      set_occ(10, 10);
      chk("R1 mask set before reset", 32'(rd_mask), 32'h1);
      rst_n = 1'b0;
      #1;
      chk("R1 rd_mask in reset", 32'(rd_mask), 0);
      chk("R1 wr_mask in reset", 32'(wr_mask), 0);
      chk("R1 be_throttle in reset", 32'(be_throttle), 0);
      rd_occ = '0;
      wr_occ = '0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rd_mask after reset", 32'(rd_mask), 0);
      rd_reg(0, d);  chk("R1 rd threshold default", 32'(d), QD);
      rd_reg(5, d);  chk("R1 wr threshold default", 32'(d), QD);
      rd_reg(10, d); chk("R1 hysteresis default", 32'(d), 0);
      rd_reg(15, d); chk("R1 class default", 32'(d), 0);
      rd_reg(16, d); chk("R1 be threshold default", 32'(d), QD);
   endtask

   task automatic t_regmap();
      logic [OCC_W-1:0] d;
      do_reset();
      wr_reg(10, 5);
      rd_reg(10, d); chk("R2 hysteresis port2 readback", 32'(d), 5);
      wr_reg(7, 1);
      rd_reg(7, d);  chk("R2 class port1 readback", 32'(d), 1);
      wr_reg(15, 6'h3E);
      rd_reg(15, d); chk("R2 class keeps bit0 only", 32'(d), 0);
      wr_reg(13, 9);
      rd_reg(13, d); chk("R2 wr threshold port3 readback", 32'(d), 9);
      wr_reg(16, 12);
      rd_reg(16, d); chk("R2 be threshold readback", 32'(d), 12);
      wr_reg(17, 7);
      rd_reg(17, d); chk("R2 unmapped reads zero", 32'(d), 0);
      wr_reg(31, 3);
      rd_reg(16, d); chk("R2 unmapped write ignored be", 32'(d), 12);
      rd_reg(0, d);  chk("R2 unmapped write ignored p0", 32'(d), QD);
   endtask

   task automatic t_rd_mask();
      do_reset();
      wr_reg(0, 10);
      wr_reg(4, 20);
      wr_reg(8, 5);
      set_occ(4, 0);  chk("R3 below all thresholds", 32'(rd_mask), 32'h0);
      set_occ(5, 0);  chk("R3 equal to port2 threshold", 32'(rd_mask), 32'h4);
      set_occ(10, 0); chk("R3 port0 and port2", 32'(rd_mask), 32'h5);
      set_occ(20, 0); chk("R3 three ports", 32'(rd_mask), 32'h7);
      chk("R4 write masks idle on read occupancy", 32'(wr_mask), 32'h0);
      set_occ(19, 0); chk("R5 zero hysteresis clears", 32'(rd_mask), 32'h5);
      set_occ(QD, 0); chk("R9 full queue hits default threshold", 32'(rd_mask), 32'hF);
   endtask

   task automatic t_wr_mask();
      do_reset();
      wr_reg(1, 3);
      wr_reg(13, 8);
      set_occ(0, 8);  chk("R4 write masks", 32'(wr_mask), 32'h9);
      chk("R4 read masks idle on write occupancy", 32'(rd_mask), 32'h0);
      set_occ(31, 8); chk("R9 one below full no read mask", 32'(rd_mask), 32'h0);
      chk("R4 write masks unaffected by read occupancy", 32'(wr_mask), 32'h9);
      set_occ(0, 5);  chk("R4 write mask port3 clears", 32'(wr_mask), 32'h1);
   endtask

   task automatic t_hyst();
      do_reset();
      wr_reg(0, 16);
      wr_reg(2, 4);
      set_occ(15, 0); chk("R5 hysteresis does not set", 32'(rd_mask[0]), 0);
      set_occ(16, 0); chk("R5 set at threshold", 32'(rd_mask[0]), 1);
      set_occ(12, 0); chk("R5 held inside band", 32'(rd_mask[0]), 1);
      set_occ(11, 0); chk("R5 cleared below band", 32'(rd_mask[0]), 0);
      set_occ(15, 0); chk("R5 stays clear inside band", 32'(rd_mask[0]), 0);
      wr_reg(4, 3);
      wr_reg(6, 5);
      set_occ(3, 0);  chk("R5 wide band set", 32'(rd_mask[1]), 1);
      set_occ(0, 0);  chk("R5 wide band never clears", 32'(rd_mask[1]), 1);
   endtask

   task automatic t_video();
      do_reset();
      wr_reg(0, 2);
      wr_reg(1, 2);
      wr_reg(4, 2);
      wr_reg(5, 2);
      wr_reg(7, 1);
      set_occ(10, 10);
      chk("R6 video port read unmasked", 32'(rd_mask), 32'h1);
      chk("R6 video port write unmasked", 32'(wr_mask), 32'h1);
      wr_reg(3, 1);
      chk("R8 old class still applied", 32'(rd_mask), 32'h1);
      step();
      chk("R6 switched to video clears read", 32'(rd_mask), 32'h0);
      chk("R6 switched to video clears write", 32'(wr_mask), 32'h0);
   endtask

   task automatic t_be();
      do_reset();
      wr_reg(16, 12);
      set_occ(11, 11); chk("R7 below threshold", 32'(be_throttle), 0);
      set_occ(12, 11); chk("R7 read reaches threshold", 32'(be_throttle), 1);
      set_occ(0, 30);  chk("R7 write above threshold", 32'(be_throttle), 1);
      set_occ(0, 11);  chk("R7 drops without hysteresis", 32'(be_throttle), 0);
   endtask

   task automatic t_write_timing();
      do_reset();
      set_occ(20, 0);
      chk("R8 default threshold no mask", 32'(rd_mask), 32'h0);
      wr_reg(8, 20);
      chk("R8 old threshold at write edge", 32'(rd_mask), 32'h0);
      step();
      chk("R8 new threshold next edge", 32'(rd_mask), 32'h4);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
   end

   initial begin
      t_reset();
      t_regmap();
      t_rd_mask();
      t_wr_mask();
      t_hyst();
      t_video();
      t_be();
      t_write_timing();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule